// File: doc/BRIEF.md
# Clock-Select Configuration Register Bank with Two-Wire Slave

This block is the control port of a multi-output clock generator. A two-wire (I2C) bus master reaches it through a slave engine. The master writes an 8-bit selection code into the register of one clock output, or into a broadcast register that updates every output at once. It reads back one register per transaction. The current register contents leave the block as a flat vector, which feeds the frequency selectors of the outputs.

Both bus lines pass through a two-flop synchroniser and a unanimity filter clocked by the system clock. The slave engine runs on the filtered levels. Two pre-decoded address-select pins pick one of nine 7-bit bus addresses. Each transfer moves exactly one data byte. A second data byte in a write is not acknowledged and is dropped.

Top module: `clkcfg_i2c_regs`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal the address picked by the select pins. Each select pin is coded 00=low, 01=open, 10=high, and 11 is read as open. The addresses for (sel1,sel0) are: low/low 0x69, low/open 0x6C, low/high 0x70, open/low 0x64, open/open 0x68, open/high 0x62, high/low 0x72, high/open 0x71, high/high 0x74.
- R2: A write (START, address with bit0=0, register pointer, data, STOP) is acknowledged on all three bytes. The data lands in the register the pointer selects. Register n appears on cfg_q[8n+7:8n].
- R3: A read (START, address with bit0=0, pointer, repeated START, address with bit0=1) returns the value of the selected register. The bits are driven most significant first.
- R4: A write to pointer 0x00 loads the data into registers 0 through NUM_OUT together.
- R5: Pointers above NUM_OUT (0x07..0xFF by default) are reserved. A write to one is acknowledged but changes no register, and a read from one returns 0x00.
- R6: After reset, register 1 holds 0x08 and registers 2 to 4 hold 0x07. Register 0 and every higher register hold 0x00.
- R7: An acknowledge holds SDA low for the whole high time of the ninth clock. The slave changes SDA only while SCL is low.
- R8: In a write, any byte after the first data byte gets no acknowledge and leaves all registers unchanged.
- R9: A STOP in any state releases SDA and aborts the transfer, and no register changes. A repeated START at any point restarts the address phase.
- R10: A pulse on SCL lasting fewer than FILT_LEN system cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sel0 | input | 2 | Pre-decoded three-level address select 0 |
| sel1 | input | 2 | Pre-decoded three-level address select 1 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_q | output | 8*(NUM_OUT+1) | Register contents, register n in byte n |

## Verification
The bench sweeps all nine select combinations plus the 11 code. A decoder with swapped pins or a wrong entry would answer the wrong address or stay silent. It writes the broadcast pointer and reserved pointers and reads them back, which catches a broadcast that misses a register and a reserved write that aliases onto a real one. It sends a second data byte in a write, aborts with STOP before the data byte, and re-addresses with a repeated START. These show an engine that auto-increments, commits too early or ignores restarts. A short SCL pulse inside a data byte shows whether an unfiltered engine would shift in an extra bit and corrupt the stored value.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_REGPTR,
        ST_WDATA,
        ST_EXTRA,
        ST_ACK,
        ST_RDATA,
        ST_IGNORE
    } slv_state_e;

    // filtered line level plus single-cycle edge flags
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_ev_t;

    localparam logic [1:0] PIN_LOW  = 2'd0;
    localparam logic [1:0] PIN_OPEN = 2'd1;
    localparam logic [1:0] PIN_HIGH = 2'd2;

    function automatic logic [1:0] norm_pin(input logic [1:0] code);
        return (code == 2'd3) ? PIN_OPEN : code;
    endfunction

    function automatic logic [6:0] dev_addr_of(input logic [1:0] s0, input logic [1:0] s1);
        logic [1:0] a0;
        logic [1:0] a1;
        a0 = norm_pin(s0);
        a1 = norm_pin(s1);
        unique case (a1)
            PIN_LOW:  return (a0 == PIN_LOW) ? 7'h69 : (a0 == PIN_OPEN) ? 7'h6C : 7'h70;
            PIN_HIGH: return (a0 == PIN_LOW) ? 7'h72 : (a0 == PIN_OPEN) ? 7'h71 : 7'h74;
            default:  return (a0 == PIN_LOW) ? 7'h64 : (a0 == PIN_OPEN) ? 7'h68 : 7'h62;
        endcase
    endfunction

    // per-register value loaded by reset
    function automatic logic [7:0] reset_code(input int unsigned idx);
        if (idx == 1)                return 8'h08;
        else if (idx >= 2 && idx <= 4) return 8'h07;
        else                         return 8'h00;
    endfunction

endpackage

// File: rtl/clkcfg_glitch_filter.sv
module clkcfg_glitch_filter
    import clkcfg_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     raw,
    output line_ev_t ev
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] win_q;
    logic                lvl_q;
    logic                lvl_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            win_q  <= '1;
            lvl_q  <= 1'b1;
            lvl_p  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            win_q  <= {win_q[FILT_LEN-2:0], sync_q[1]};
            // level moves only once the whole window agrees
            if (&win_q)
                lvl_q <= 1'b1;
            else if (~|win_q)
                lvl_q <= 1'b0;
            lvl_p <= lvl_q;
        end
    end

    assign ev.lvl  = lvl_q;
    assign ev.rise = lvl_q & ~lvl_p;
    assign ev.fall = ~lvl_q & lvl_p;

endmodule

// File: rtl/clkcfg_slave_fsm.sv
module clkcfg_slave_fsm
    import clkcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   scl,
    input  line_ev_t   sda,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] ptr,
    output logic [7:0] wr_data
);
    slv_state_e st_q;
    slv_state_e ack_nxt_q;
    logic [3:0] bitcnt_q;
    logic [7:0] rx_q;
    logic [7:0] tx_q;
    logic       wrote_q;

    logic ev_start;
    logic ev_stop;
    assign ev_start = sda.fall & scl.lvl & ~scl.rise;
    assign ev_stop  = sda.rise & scl.lvl & ~scl.rise;

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            st_q      <= ST_IDLE;
            ack_nxt_q <= ST_IDLE;
            bitcnt_q  <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            ptr       <= '0;
            wr_data   <= '0;
            sda_oe    <= 1'b0;
            wrote_q   <= 1'b0;
        end else if (ev_stop) begin
            st_q    <= ST_IDLE;
            sda_oe  <= 1'b0;
            wrote_q <= 1'b0;
        end else if (ev_start) begin
            st_q     <= ST_DEVADDR;
            bitcnt_q <= '0;
            sda_oe   <= 1'b0;
            wrote_q  <= 1'b0;
        end else if (scl.rise) begin
            unique case (st_q)
                ST_DEVADDR, ST_REGPTR, ST_WDATA, ST_EXTRA: begin
                    rx_q     <= {rx_q[6:0], sda.lvl};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end
                ST_ACK, ST_RDATA: bitcnt_q <= bitcnt_q + 4'd1;
                default: ;
            endcase
        end else if (scl.fall) begin
            unique case (st_q)
                ST_DEVADDR: if (bitcnt_q == 4'd8) begin
                    if (rx_q[7:1] == dev_addr) begin
                        sda_oe    <= 1'b1;
                        st_q      <= ST_ACK;
                        ack_nxt_q <= rx_q[0] ? ST_RDATA : ST_REGPTR;
                    end else begin
                        st_q <= ST_IGNORE;
                    end
                end
                ST_REGPTR: if (bitcnt_q == 4'd8) begin
                    ptr       <= rx_q;
                    sda_oe    <= 1'b1;
                    st_q      <= ST_ACK;
                    ack_nxt_q <= ST_WDATA;
                end
                ST_WDATA: if (bitcnt_q == 4'd8) begin
                    wr_en     <= 1'b1;
                    wr_data   <= rx_q;
                    wrote_q   <= 1'b1;
                    sda_oe    <= 1'b1;
                    st_q      <= ST_ACK;
                    ack_nxt_q <= ST_EXTRA;
                end
                ST_EXTRA: if (bitcnt_q == 4'd9) bitcnt_q <= '0;
                ST_ACK: if (bitcnt_q == 4'd9) begin
                    bitcnt_q <= '0;
                    st_q     <= ack_nxt_q;
                    if (ack_nxt_q == ST_RDATA) begin
                        tx_q   <= rd_data;
                        sda_oe <= ~rd_data[7];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
                ST_RDATA: if (bitcnt_q == 4'd8) begin
                    sda_oe <= 1'b0;
                    st_q   <= ST_IGNORE;
                end else if (bitcnt_q != 4'd0) begin
                    sda_oe <= ~tx_q[6];
                    tx_q   <= {tx_q[6:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    // R7: the data line is only touched while the clock is low
    a_r7_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl.lvl);

    // R9: a STOP returns to idle with the line released
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (st_q == ST_IDLE && !sda_oe));

    // R8: at most one register write per addressed frame
    a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(wrote_q) == 1'b0);

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int NREG = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] cfg_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= reset_code(i);
            else if (wr_en && (addr == 8'(i) || addr == 8'd0))
                q <= wr_data;
        end
        assign cfg_q[i*8 +: 8] = q;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (addr == 8'(i))
                rd_data = cfg_q[i*8 +: 8];
    end

    // R4: broadcast pointer fills every register with the same byte
    a_r4_broadcast_all: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'd0) |=> cfg_q == {NREG{$past(wr_data)}});

    // R5: reserved pointer leaves the bank untouched
    a_r5_reserved_discard: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= 8'(NREG)) |=> $stable(cfg_q));

endmodule

// File: rtl/clkcfg_i2c_regs.sv
module clkcfg_i2c_regs
    import clkcfg_pkg::*;
#(
    parameter int NUM_OUT  = 6,
    parameter int FILT_LEN = 3,
    localparam int NREG    = NUM_OUT + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        sel0,
    input  logic [1:0]        sel1,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_q
);
    logic [1:0] raw;
    line_ev_t   ev [2];
    logic       wr_en;
    logic [7:0] ptr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [6:0] dev_addr;

    assign raw      = {sda_i, scl_i};
    assign dev_addr = dev_addr_of(sel0, sel1);

    for (genvar g = 0; g < 2; g++) begin : g_filt
        clkcfg_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk (clk),
            .rst (rst),
            .raw (raw[g]),
            .ev  (ev[g])
        );
    end

    clkcfg_slave_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl      (ev[0]),
        .sda      (ev[1]),
        .dev_addr (dev_addr),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .ptr      (ptr),
        .wr_data  (wr_data)
    );

    clkcfg_regbank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (ptr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

endmodule

// File: tb/sim_clkcfg_i2c_regs.sv
module sim_clkcfg_i2c_regs;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] sel0 = 2'd1;
    logic [1:0] sel1 = 2'd1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_q;
    logic line;
    logic glitch = 1'b0;

    assign line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_i2c_regs u0 (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m | glitch),
        .sda_i  (line),
        .sel0   (sel0),
        .sel1   (sel1),
        .sda_oe (sda_oe),
        .cfg_q  (cfg_q)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [NREG];
    bit done = 0;

    function automatic logic [6:0] addr_model(input logic [1:0] s0, input logic [1:0] s1);
        logic [6:0] tbl [9] = '{7'h69, 7'h6C, 7'h70, 7'h64, 7'h68, 7'h62, 7'h72, 7'h71, 7'h74};
        int a0;
        int a1;
        a0 = (s0 == 2'd3) ? 1 : int'(s0);
        a1 = (s1 == 2'd3) ? 1 : int'(s1);
        return tbl[a1*3 + a0];
    endfunction

    function automatic logic [NREG*8-1:0] pack_model();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    function automatic logic [7:0] read_model(input logic [7:0] r);
        return (r < NREG) ? model[r] : 8'h00;
    endfunction

    task automatic model_write(input logic [7:0] r, input logic [7:0] d);
        if (r == 8'd0) for (int i = 0; i < NREG; i++) model[i] = d;
        else if (r < NREG) model[r] = d;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; hq(Q);
        scl_m = 1'b1; hq(Q);
        sda_m = 1'b0; hq(Q);
        scl_m = 1'b0; hq(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; hq(Q);
        scl_m = 1'b1; hq(Q);
        sda_m = 1'b1; hq(2*Q);
    endtask

    // glitch_bit >= 0 adds a 2-cycle SCL pulse in that bit's low phase
    task automatic send_byte(input logic [7:0] b, input int glitch_bit,
                             output bit acked, output bit held);
        logic a0, a1;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq(2);
            if (i == glitch_bit) begin
                glitch = 1'b1; hq(2); glitch = 1'b0; hq(Q-4);
            end else hq(Q-2);
            scl_m = 1'b1; hq(2*Q);
            scl_m = 1'b0; hq(Q);
        end
        sda_m = 1'b1; hq(Q);
        scl_m = 1'b1; hq(1); a0 = line;
        hq(2*Q-2); a1 = line; hq(1);
        scl_m = 1'b0; hq(Q);
        acked = !a1;
        held  = (a0 == a1);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hq(Q); scl_m = 1'b1; hq(Q); b[i] = line; hq(Q); scl_m = 1'b0; hq(Q);
        end
        sda_m = nack; hq(Q);
        scl_m = 1'b1; hq(2*Q);
        scl_m = 1'b0; hq(Q);
    endtask

    task automatic wr_tx(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                         output logic [2:0] acks);
        bit k, h;
        bstart();
        send_byte({a, 1'b0}, -1, k, h); acks[2] = k;
        send_byte(r, -1, k, h);         acks[1] = k;
        send_byte(d, -1, k, h);         acks[0] = k;
        bstop();
    endtask

    task automatic rd_tx(input logic [6:0] a, input logic [7:0] r, output logic [7:0] d,
                         output logic [2:0] acks);
        bit k, h;
        bstart();
        send_byte({a, 1'b0}, -1, k, h); acks[2] = k;
        send_byte(r, -1, k, h);         acks[1] = k;
        bstart();
        send_byte({a, 1'b1}, -1, k, h); acks[0] = k;
        recv_byte(1'b1, d);
        bstop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] rd;
        logic [6:0] adr;
        bit k, h;
        void'($urandom(32'd1791));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        model[1] = 8'h08; model[2] = 8'h07; model[3] = 8'h07; model[4] = 8'h07;
        hq(5); rst = 1'b0; hq(5);

        // R6: reset contents and released line
        check("R6 reset cfg", 64'(cfg_q), 64'(pack_model()));
        check("R6 reset sda_oe", 64'(sda_oe), 64'd0);

        // R2/R3: plain write and read back
        adr = 7'h68;
        wr_tx(adr, 8'd3, 8'hA5, acks); model_write(8'd3, 8'hA5);
        check("R2 write acks", 64'(acks), 64'b111);
        check("R2 write reg3", 64'(cfg_q), 64'(pack_model()));
        rd_tx(adr, 8'd3, rd, acks);
        check("R3 read acks", 64'(acks), 64'b111);
        check("R3 read reg3", 64'(rd), 64'hA5);
        rd_tx(adr, 8'd1, rd, acks);
        check("R3 read reg1", 64'(rd), 64'h08);

        // R7: acknowledge held across the whole ninth high phase
        bstart();
        send_byte({adr, 1'b0}, -1, k, h);
        check("R7 ack low", 64'(k), 64'd1);
        check("R7 ack held", 64'(h), 64'd1);
        bstop();

        // R4: broadcast pointer
        wr_tx(adr, 8'd0, 8'h3C, acks); model_write(8'd0, 8'h3C);
        check("R4 broadcast", 64'(cfg_q), 64'(pack_model()));

        // R5: reserved pointers
        wr_tx(adr, 8'd7, 8'h55, acks);
        check("R5 reserved write ack", 64'(acks), 64'b111);
        check("R5 reserved write discarded", 64'(cfg_q), 64'(pack_model()));
        wr_tx(adr, 8'hFF, 8'h99, acks);
        check("R5 reserved 0xFF discarded", 64'(cfg_q), 64'(pack_model()));
        rd_tx(adr, 8'd9, rd, acks);
        check("R5 reserved read zero", 64'(rd), 64'h00);

        // R8: second data byte refused
        bstart();
        send_byte({adr, 1'b0}, -1, k, h);
        send_byte(8'd6, -1, k, h);
        send_byte(8'h11, -1, k, h); model_write(8'd6, 8'h11);
        send_byte(8'h22, -1, k, h);
        check("R8 extra byte nack", 64'(k), 64'd0);
        bstop();
        check("R8 extra byte ignored", 64'(cfg_q), 64'(pack_model()));

        // R9: STOP before data, then repeated START redirecting a write
        bstart();
        send_byte({adr, 1'b0}, -1, k, h);
        send_byte(8'd4, -1, k, h);
        bstop();
        check("R9 stop abort no write", 64'(cfg_q), 64'(pack_model()));
        check("R9 stop releases sda", 64'(sda_oe), 64'd0);
        bstart();
        send_byte({adr, 1'b0}, -1, k, h);
        send_byte(8'd4, -1, k, h);
        bstart();
        send_byte({adr, 1'b0}, -1, k, h);
        check("R9 restart readdress ack", 64'(k), 64'd1);
        send_byte(8'd2, -1, k, h);
        send_byte(8'hC3, -1, k, h); model_write(8'd2, 8'hC3);
        bstop();
        check("R9 restart write", 64'(cfg_q), 64'(pack_model()));

        // R10: short SCL pulse inside a data byte
        bstart();
        send_byte({adr, 1'b0}, -1, k, h);
        send_byte(8'd5, -1, k, h);
        send_byte(8'h96, 3, k, h); model_write(8'd5, 8'h96);
        bstop();
        check("R10 glitch ack", 64'(k), 64'd1);
        check("R10 glitch data", 64'(cfg_q), 64'(pack_model()));

        // R1: every select combination plus the 11 code
        for (int s1 = 0; s1 < 3; s1++) begin
            for (int s0 = 0; s0 < 3; s0++) begin
                sel0 = 2'(s0); sel1 = 2'(s1); hq(2);
                adr = addr_model(sel0, sel1);
                wr_tx(adr, 8'd1, 8'(s1*3 + s0), acks); model_write(8'd1, 8'(s1*3 + s0));
                check("R1 own address ack", 64'(acks), 64'b111);
                bstart();
                send_byte({addr_model(2'(s1), 2'(s0)) ^ 7'h01, 1'b0}, -1, k, h);
                bstop();
                check("R1 foreign address nack", 64'(k), 64'd0);
            end
        end
        check("R1 sweep contents", 64'(cfg_q), 64'(pack_model()));
        sel0 = 2'd3; sel1 = 2'd0; hq(2);
        wr_tx(7'h6C, 8'd6, 8'h5A, acks); model_write(8'd6, 8'h5A);
        check("R1 code 11 as open", 64'(acks), 64'b111);
        sel0 = 2'd1; sel1 = 2'd1; hq(2);
        adr = 7'h68;

        // R2/R3/R4/R5: random traffic against the model
        for (int n = 0; n < 30; n++) begin
            logic [7:0] r, d, rr;
            r  = 8'($urandom_range(0, 9));
            d  = 8'($urandom);
            rr = 8'($urandom_range(0, 9));
            wr_tx(adr, r, d, acks); model_write(r, d);
            check("R2 random write", 64'(cfg_q), 64'(pack_model()));
            rd_tx(adr, rr, rd, acks);
            check("R3 random read", 64'(rd), 64'(read_model(rr)));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule